// File: doc/BRIEF.md
# Slotted Two-by-Two Deflection Routing Node

This block makes the routing decision for one self-routing node in a hierarchical, bufferless deflection network. Time is cut into fixed packet slots, each made of a run of active cycles followed by guard cycles. Two inputs can bring a packet into the node. The in-ring input carries packets that are circulating on the node's own ring. The injection input carries packets that arrive from the outer level. Each input supplies a frame-present bit, a header field and a payload bus. A blocking input from the downstream node reports that the inward path is reserved for this slot.

In the first cycle of a slot the node reads exactly one header bit, chosen by its level parameter. If that bit matches the node's position bit and the inward path is free, the packet goes south, toward the inner level. In every other case it goes east, staying on the ring, so that a later node can move it inward. The choice is held for the rest of the active window. While the node carries a packet it raises a hold signal toward the upstream node, which tells that node to deflect anything that would collide with it. The header and payload of the chosen input leave the node unchanged on a shared output bus. Which optical path carries them is given by the two enables.

The node never stores a packet. If both inputs are framed in the same slot, the control protocol has been broken. The in-ring packet wins and a sticky error flag is raised.

Top module: `defl_node`

## Requirements
- R1: In every slot where at least one input is framed in the slot's first cycle, exactly one of `east_en` and `south_en` is high in each active cycle of that slot. The two are never high together.
- R2: When the winning packet's header bit at index LEVEL equals POS_BIT (default LEVEL=1, POS_BIT=1) and `south_block` is low in the first cycle, `south_en` is high for the active window.
- R3: When the winning packet's header bit at index LEVEL differs from POS_BIT, `east_en` is high for the active window. Header bits other than index LEVEL have no effect on the path.
- R4: When `south_block` is high in a slot's first cycle, a framed packet goes east whatever its header bit is, and `south_en` stays low for the whole slot.
- R5: The path is fixed in the first cycle of the slot. Later changes to the header bit or to `south_block` within the same slot do not change `east_en` or `south_en`.
- R6: In the GUARD_CYC cycles that follow the ACT_CYC active cycles of a slot (defaults 6 and 2), `east_en`, `south_en` and `up_hold` are all low.
- R7: When neither input is framed in a slot's first cycle, `east_en`, `south_en` and `up_hold` stay low and `out_hdr` and `out_data` read zero for the whole slot.
- R8: `up_hold` is high in exactly those cycles in which one of the two enables is high.
- R9: While a packet is carried, `out_hdr` and `out_data` equal the current header and payload of the winning input. When no packet is carried, both read zero.
- R10: When both inputs are framed in a slot's first cycle, the in-ring input is routed. `proto_err` goes high from the second cycle of that slot and stays high until reset.
- R11: While `rst_n` is low, `east_en`, `south_en`, `up_hold` and `proto_err` are low. The first slot starts in the cycle in which `rst_n` is first seen high.
- R12: A packet that is framed only on the injection input is routed by the same rule as an in-ring packet, and its header and payload appear on the output bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_frame | input | 1 | Frame present on the in-ring input |
| ring_hdr | input | ADDR_W | Header field of the in-ring packet |
| ring_data | input | DATA_W | Payload of the in-ring packet |
| inj_frame | input | 1 | Frame present on the injection input |
| inj_hdr | input | ADDR_W | Header field of the injected packet |
| inj_data | input | DATA_W | Payload of the injected packet |
| south_block | input | 1 | Downstream node has reserved the inward path |
| east_en | output | 1 | Enable for the ring (east) path |
| south_en | output | 1 | Enable for the inward (south) path |
| up_hold | output | 1 | Control to the upstream node: this node is carrying a packet |
| out_hdr | output | ADDR_W | Header of the carried packet, zero when idle |
| out_data | output | DATA_W | Payload of the carried packet, zero when idle |
| proto_err | output | 1 | Sticky flag: both inputs were framed in one slot |

## Verification
The assertions assume that the frame bits and the blocking input only carry meaning in a slot's first cycle, and that upstream logic keeps packets aligned to the slot grid. Under that assumption, enables may rise only in a first cycle. The stimulus is applied at falling edges, in step with the slot grid that starts at reset release. Frames are asserted only during the active window and the guard cycles are left quiet. Both inputs are framed together only in the one scenario that targets the protocol error. Header bits and the blocking input are changed in the middle of a slot only in the scenarios that check that the held path ignores such changes.

// File: rtl/defl_pkg.sv
package defl_pkg;

   typedef enum logic [1:0] {
      PATH_IDLE  = 2'b00,
      PATH_EAST  = 2'b01,
      PATH_SOUTH = 2'b10
   } path_e;

   typedef enum logic {
      SRC_RING = 1'b0,
      SRC_INJ  = 1'b1
   } src_e;

endpackage

// File: rtl/defl_slot_timer.sv
module defl_slot_timer #(
   parameter int ACT_CYC   = 6,
   parameter int GUARD_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic slot_start,
   output logic active
);
   localparam int SLOT_LEN  = ACT_CYC + GUARD_CYC;
   localparam int PH_W      = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1;
   localparam bit WRAP_FREE = (SLOT_LEN == (1 << PH_W));

   if (ACT_CYC < 1) begin : g_bad_act
      $error("defl_slot_timer: ACT_CYC must be at least 1");
   end
   if (GUARD_CYC < 1) begin : g_bad_guard
      $error("defl_slot_timer: GUARD_CYC must be at least 1");
   end

   logic [PH_W-1:0] phase;

   if (WRAP_FREE) begin : g_wrap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) phase <= '0;
         else        phase <= phase + 1'b1;
      end
   end else begin : g_cmp
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                            phase <= '0;
         else if (phase == PH_W'(SLOT_LEN - 1)) phase <= '0;
         else                                   phase <= phase + 1'b1;
      end
   end

   assign slot_start = rst_n && (phase == '0);
   assign active     = rst_n && (phase < PH_W'(ACT_CYC));

endmodule

// File: rtl/defl_route_sel.sv
module defl_route_sel
   import defl_pkg::*;
#(
   parameter bit POS_BIT = 1'b1
) (
   input  logic  ring_vld,
   input  logic  ring_key,
   input  logic  inj_vld,
   input  logic  inj_key,
   input  logic  blocked,
   output path_e path,
   output src_e  src,
   output logic  clash
);
   logic key;
   logic any_vld;

   always_comb begin
      src     = ring_vld ? SRC_RING : SRC_INJ;
      key     = ring_vld ? ring_key : inj_key;
      any_vld = ring_vld || inj_vld;
      clash   = ring_vld && inj_vld;
      if (!any_vld)
         path = PATH_IDLE;
      else if (!blocked && (key == POS_BIT))
         path = PATH_SOUTH;
      else
         path = PATH_EAST;
   end

endmodule

// File: rtl/defl_path_hold.sv
module defl_path_hold
   import defl_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  slot_start,
   input  logic  active,
   input  path_e new_path,
   input  src_e  new_src,
   input  logic  clash,
   output path_e cur_path,
   output src_e  cur_src,
   output logic  err
);
   path_e held_path;
   src_e  held_src;
   logic  err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_path <= PATH_IDLE;
         held_src  <= SRC_RING;
         err_q     <= 1'b0;
      end else if (slot_start) begin
         held_path <= new_path;
         held_src  <= new_src;
         err_q     <= err_q | clash;
      end
   end

   always_comb begin
      if (slot_start) begin
         cur_path = new_path;
         cur_src  = new_src;
      end else if (active) begin
         cur_path = held_path;
         cur_src  = held_src;
      end else begin
         cur_path = PATH_IDLE;
         cur_src  = SRC_RING;
      end
   end

   assign err = err_q;

endmodule

// File: rtl/defl_node.sv
module defl_node
   import defl_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int ADDR_W    = 4,
   parameter int LEVEL     = 1,
   parameter bit POS_BIT   = 1'b1,
   parameter int ACT_CYC   = 6,
   parameter int GUARD_CYC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ring_frame,
   input  logic [ADDR_W-1:0] ring_hdr,
   input  logic [DATA_W-1:0] ring_data,
   input  logic              inj_frame,
   input  logic [ADDR_W-1:0] inj_hdr,
   input  logic [DATA_W-1:0] inj_data,
   input  logic              south_block,
   output logic              east_en,
   output logic              south_en,
   output logic              up_hold,
   output logic [ADDR_W-1:0] out_hdr,
   output logic [DATA_W-1:0] out_data,
   output logic              proto_err
);
   if (LEVEL < 0 || LEVEL >= ADDR_W) begin : g_bad_level
      $error("defl_node: LEVEL must index a bit of the header");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("defl_node: DATA_W must be at least 1");
   end

   logic  slot_start;
   logic  active;
   path_e new_path;
   src_e  new_src;
   logic  clash;
   path_e cur_path;
   src_e  cur_src;
   logic  carry;

   defl_slot_timer #(
      .ACT_CYC   (ACT_CYC),
      .GUARD_CYC (GUARD_CYC)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .slot_start (slot_start),
      .active     (active)
   );

   defl_route_sel #(
      .POS_BIT (POS_BIT)
   ) u_route (
      .ring_vld (ring_frame),
      .ring_key (ring_hdr[LEVEL]),
      .inj_vld  (inj_frame),
      .inj_key  (inj_hdr[LEVEL]),
      .blocked  (south_block),
      .path     (new_path),
      .src      (new_src),
      .clash    (clash)
   );

   defl_path_hold u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .slot_start (slot_start),
      .active     (active),
      .new_path   (new_path),
      .new_src    (new_src),
      .clash      (clash),
      .cur_path   (cur_path),
      .cur_src    (cur_src),
      .err        (proto_err)
   );

   assign carry    = (cur_path != PATH_IDLE);
   assign east_en  = (cur_path == PATH_EAST);
   assign south_en = (cur_path == PATH_SOUTH);
   assign up_hold  = carry;

   always_comb begin
      out_hdr  = '0;
      out_data = '0;
      if (carry) begin
         if (cur_src == SRC_RING) begin
            out_hdr  = ring_hdr;
            out_data = ring_data;
         end else begin
            out_hdr  = inj_hdr;
            out_data = inj_data;
         end
      end
   end

endmodule

// File: rtl/defl_node_chk.sv
module defl_node_chk #(
   parameter int ACT_CYC = 6
) (
   input logic clk,
   input logic rst_n,
   input logic slot_start,
   input logic ring_frame,
   input logic inj_frame,
   input logic south_block,
   input logic east_en,
   input logic south_en,
   input logic up_hold,
   input logic proto_err
);
   logic [15:0] since_start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 since_start <= '0;
      else if (slot_start)        since_start <= 16'd1;
      else if (since_start != '1) since_start <= since_start + 16'd1;
   end

   // R1
   framed_one_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_start && (ring_frame || inj_frame)) |-> (east_en ^ south_en));

   // R1
   never_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
      east_en |-> !south_en);

   // R4
   blocked_no_south_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_start && south_block) |-> !south_en);

   // R5
   east_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!slot_start && east_en) |-> $past(east_en));

   // R5
   south_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!slot_start && south_en) |-> $past(south_en));

   // R6
   guard_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!slot_start && since_start >= 16'(ACT_CYC)) |-> (!east_en && !south_en && !up_hold));

   // R7
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_start && !ring_frame && !inj_frame) |-> (!east_en && !south_en && !up_hold));

   // R8
   hold_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (east_en || south_en) |-> up_hold);

   // R8
   hold_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      up_hold |-> (east_en || south_en));

   // R10
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(proto_err) |-> proto_err);

   // R10
   err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_start && ring_frame && inj_frame) |=> proto_err);

endmodule

bind defl_node defl_node_chk #(
   .ACT_CYC (ACT_CYC)
) u_defl_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .slot_start  (slot_start),
   .ring_frame  (ring_frame),
   .inj_frame   (inj_frame),
   .south_block (south_block),
   .east_en     (east_en),
   .south_en    (south_en),
   .up_hold     (up_hold),
   .proto_err   (proto_err)
);

// File: tb/tb_defl_node.sv
module tb_defl_node;
   localparam int DATA_W = 16;
   localparam int ADDR_W = 4;
   localparam int LEVEL  = 1;
   localparam bit POS_B  = 1'b1;
   localparam int ACT    = 6;
   localparam int GUARD  = 2;
   localparam int SLOT   = ACT + GUARD;

   localparam int P_IDLE  = 0;
   localparam int P_EAST  = 1;
   localparam int P_SOUTH = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ring_frame = 1'b0;
   logic [ADDR_W-1:0] ring_hdr = '0;
   logic [DATA_W-1:0] ring_data = '0;
   logic              inj_frame = 1'b0;
   logic [ADDR_W-1:0] inj_hdr = '0;
   logic [DATA_W-1:0] inj_data = '0;
   logic              south_block = 1'b0;
   logic              east_en, south_en, up_hold, proto_err;
   logic [ADDR_W-1:0] out_hdr;
   logic [DATA_W-1:0] out_data;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  err_model = 1'b0;
   bit  done = 1'b0;

   always #10 clk = ~clk;

   defl_node #(
      .DATA_W (DATA_W), .ADDR_W (ADDR_W), .LEVEL (LEVEL),
      .POS_BIT (POS_B), .ACT_CYC (ACT), .GUARD_CYC (GUARD)
   ) dut (
      .clk (clk), .rst_n (rst_n),
      .ring_frame (ring_frame), .ring_hdr (ring_hdr), .ring_data (ring_data),
      .inj_frame (inj_frame), .inj_hdr (inj_hdr), .inj_data (inj_data),
      .south_block (south_block),
      .east_en (east_en), .south_en (south_en), .up_hold (up_hold),
      .out_hdr (out_hdr), .out_data (out_data), .proto_err (proto_err)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic drive_quiet();
      ring_frame = 1'b0; ring_hdr = '0; ring_data = '0;
      inj_frame = 1'b0; inj_hdr = '0; inj_data = '0;
      south_block = 1'b0;
   endtask

   // One slot, entered at the falling edge that opens slot cycle 0.
   task automatic run_slot(input string tag,
                           input logic rf, input logic [ADDR_W-1:0] rh, input logic [DATA_W-1:0] rd,
                           input logic jf, input logic [ADDR_W-1:0] jh, input logic [DATA_W-1:0] jd,
                           input logic blk, input bit perturb, input int exp_path);
      bit err_next;
      err_next = err_model | (rf & jf);
      for (int c = 0; c < SLOT; c++) begin
         logic [ADDR_W-1:0] flip;
         logic [ADDR_W-1:0] eh;
         logic [DATA_W-1:0] ed;
         int                ep;
         flip = (perturb && c > 0) ? ADDR_W'(1 << LEVEL) : '0;
         if (c < ACT) begin
            ring_frame  = rf;
            ring_hdr    = rh ^ flip;
            ring_data   = rd + DATA_W'(c);
            inj_frame   = jf;
            inj_hdr     = jh ^ flip;
            inj_data    = jd + DATA_W'(c);
            south_block = (perturb && c > 0) ? ~blk : blk;
         end else begin
            drive_quiet();
         end
         #5;
         ep = (c < ACT) ? exp_path : P_IDLE;
         if (ep == P_IDLE) begin
            eh = '0; ed = '0;
         end else if (rf) begin
            eh = ring_hdr; ed = ring_data;
         end else begin
            eh = inj_hdr; ed = inj_data;
         end
         if (c >= ACT) begin
            check("R6", "guard east_en", 32'(east_en), 32'(0));
            check("R6", "guard south_en", 32'(south_en), 32'(0));
            check("R6", "guard up_hold", 32'(up_hold), 32'(0));
         end else begin
            check(tag, perturb ? "held east_en (R5)" : "east_en", 32'(east_en), 32'(ep == P_EAST));
            check(tag, perturb ? "held south_en (R5)" : "south_en", 32'(south_en), 32'(ep == P_SOUTH));
            check("R8", "up_hold", 32'(up_hold), 32'(ep != P_IDLE));
         end
         check("R9", "out_hdr", 32'(out_hdr), 32'(eh));
         check("R9", "out_data", 32'(out_data), 32'(ed));
         check("R10", "proto_err", 32'(proto_err), 32'((c == 0) ? err_model : err_next));
         @(negedge clk);
      end
      err_model = err_next;
   endtask

   task automatic t_reset_state();
      // R11: outputs quiet while reset is held
      check("R11", "east_en in reset", 32'(east_en), 32'(0));
      check("R11", "south_en in reset", 32'(south_en), 32'(0));
      check("R11", "up_hold in reset", 32'(up_hold), 32'(0));
      check("R11", "proto_err in reset", 32'(proto_err), 32'(0));
      check("R11", "out_data in reset", 32'(out_data), 32'(0));
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      drive_quiet();
      #5;
      t_reset_state();
      @(negedge clk);
      rst_n = 1'b1;
      err_model = 1'b0;
   endtask

   task automatic t_idle();
      run_slot("R7", 1'b0, 4'hF, 16'h1234, 1'b0, 4'hF, 16'h5678, 1'b0, 1'b0, P_IDLE);
   endtask

   task automatic t_ring_south();
      run_slot("R2", 1'b1, 4'b0010, 16'hA000, 1'b0, '0, '0, 1'b0, 1'b0, P_SOUTH);
      // R3: other header bits do not matter
      run_slot("R3", 1'b1, 4'b1111, 16'hA100, 1'b0, '0, '0, 1'b0, 1'b0, P_SOUTH);
   endtask

   task automatic t_ring_east();
      run_slot("R3", 1'b1, 4'b1101, 16'hB000, 1'b0, '0, '0, 1'b0, 1'b0, P_EAST);
      run_slot("R3", 1'b1, 4'b0000, 16'hB100, 1'b0, '0, '0, 1'b0, 1'b0, P_EAST);
   endtask

   task automatic t_blocked();
      run_slot("R4", 1'b1, 4'b0010, 16'hC000, 1'b0, '0, '0, 1'b1, 1'b0, P_EAST);
      run_slot("R4", 1'b0, '0, '0, 1'b1, 4'b0110, 16'hC100, 1'b1, 1'b0, P_EAST);
   endtask

   task automatic t_inject_only();
      run_slot("R12", 1'b0, '0, '0, 1'b1, 4'b1010, 16'hD000, 1'b0, 1'b0, P_SOUTH);
      run_slot("R12", 1'b0, '0, '0, 1'b1, 4'b1001, 16'hD100, 1'b0, 1'b0, P_EAST);
   endtask

   task automatic t_hold();
      // R5: header bit and block flip after the first cycle
      run_slot("R5", 1'b1, 4'b0010, 16'hE000, 1'b0, '0, '0, 1'b0, 1'b1, P_SOUTH);
      run_slot("R5", 1'b1, 4'b0010, 16'hE100, 1'b0, '0, '0, 1'b1, 1'b1, P_EAST);
      run_slot("R5", 1'b0, '0, '0, 1'b1, 4'b0000, 16'hE200, 1'b0, 1'b1, P_EAST);
   endtask

   task automatic t_clash();
      // R10: ring input (east) wins over injected packet (south)
      run_slot("R10", 1'b1, 4'b0100, 16'hF000, 1'b1, 4'b0010, 16'h0F00, 1'b0, 1'b0, P_EAST);
      run_slot("R1", 1'b1, 4'b0010, 16'hF100, 1'b0, '0, '0, 1'b0, 1'b0, P_SOUTH);
      run_slot("R7", 1'b0, '0, '0, 1'b0, '0, '0, 1'b0, 1'b0, P_IDLE);
   endtask

   initial begin
      drive_quiet();
      repeat (2) @(negedge clk);
      #5;
      t_reset_state();
      @(negedge clk);
      rst_n = 1'b1;
      t_idle();
      t_ring_south();
      t_ring_east();
      t_blocked();
      t_inject_only();
      t_hold();
      t_clash();
      do_reset();
      check("R11", "proto_err after reset", 32'(proto_err), 32'(0));
      run_slot("R1", 1'b1, 4'b1110, 16'h7777, 1'b0, '0, '0, 1'b0, 1'b0, P_SOUTH);
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule